// File: doc/BRIEF.md
# Per-Agent Memory Request Arbiter

This block decides which of five requesting agents owns the single command port of a memory controller, and for how long. Every agent presents a valid strobe, a burst length and a command word. The arbiter registers a one-hot grant and forwards the granted agent's command and burst length to the port. An agent's command is taken in every cycle in which that agent holds the grant and its valid strobe is high.

Each agent has three programmable settings. The first is a grant quota: the number of commands it may issue before the port is handed on. The second is a burst ceiling: a command whose burst is longer than this is still taken, but it ends the tenure. The third is a patience period, counted in steps of four clocks. An agent that has waited that long jumps ahead of round-robin order. Software first writes an agent index to a select register, then writes the value to one of the three setting registers.

Top module: `agent_port_arbiter`

## Requirements
- R1: After reset, `grant` is all zero and `cmd_valid` is low.
- R2: A write with `cfg_addr`=0 stores `cfg_wdata` as the selected agent index. A write with `cfg_addr`=1, 2 or 3 sets the burst ceiling, the patience period or the grant quota of the selected agent, and only of that agent.
- R3: `grant` is one-hot or zero, and a new grant goes only to an agent whose `req_valid` bit was high at the arbitration edge.
- R4: `cmd_valid` is high exactly when the granted agent's `req_valid` is high. `cmd_out` and `cmd_blen` then carry that agent's `req_cmd` and `req_blen` slices (agent i at bits i*32 and i*8).
- R5: A granted agent keeps the grant while it issues commands, until it has issued as many as its grant quota.
- R6: If the granted agent lowers `req_valid`, the grant moves on at the next edge, and never back to that agent at that edge.
- R7: A command whose burst length exceeds the agent's burst ceiling is taken, and the tenure ends with it. The issue count restarts from zero.
- R8: A requesting agent that has waited without a grant for at least 4 times its patience period clocks wins the next arbitration over non-waiting agents.
- R9: Otherwise, the next grant goes to the first requesting agent after the last granted one, in increasing index order with wrap-around. After reset the search starts at agent 0.
- R10: Reset values: burst ceiling 0x1f, 0x1f, 0x1f, 0x04, 0x04; grant quota 0x04, 0x10, 0x10, 0x04, 0x04; patience period 0xff for agents 0 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 select, 1 burst ceiling, 2 patience period, 3 grant quota |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 5 | Per-agent command valid |
| req_blen | input | 40 | Per-agent burst length, 8 bits each |
| req_cmd | input | 160 | Per-agent command word, 32 bits each |
| grant | output | 5 | One-hot port owner |
| cmd_valid | output | 1 | Forwarded command is valid |
| cmd_blen | output | 8 | Forwarded burst length |
| cmd_out | output | 32 | Forwarded command word |

## Verification
The properties assume an agent that holds the grant treats every cycle with its valid strobe high as one accepted command. They also assume configuration writes arrive only while no agent requests, so the settings cannot change under a running tenure. The bench models each agent as a command counter that advances only on an accepted cycle. It drives requests and configuration one step after the clock edge, and it reprograms settings only between idle scenarios.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned PARAM_W      = 8;
  localparam int unsigned PERIOD_SHIFT = 2;
  localparam int unsigned WAIT_W       = PARAM_W + PERIOD_SHIFT;

  typedef enum logic [1:0] {
    CFG_SEL    = 2'd0,
    CFG_LIMIT  = 2'd1,
    CFG_PERIOD = 2'd2,
    CFG_ACCEPT = 2'd3
  } cfg_reg_e;

  function automatic logic [PARAM_W-1:0] reset_limit(int unsigned agent);
    return (agent < 3) ? PARAM_W'(8'h1f) : PARAM_W'(8'h04);
  endfunction

  function automatic logic [PARAM_W-1:0] reset_accept(int unsigned agent);
    return (agent == 1 || agent == 2) ? PARAM_W'(8'h10) : PARAM_W'(8'h04);
  endfunction

  function automatic logic [PARAM_W-1:0] reset_period(int unsigned agent);
    return (agent < 64) ? PARAM_W'(8'hff) : PARAM_W'(8'hff);
  endfunction

  // patience in clocks: period times four
  function automatic logic [WAIT_W-1:0] wait_threshold(logic [PARAM_W-1:0] period);
    return {period, {PERIOD_SHIFT{1'b0}}};
  endfunction

  // true when the command now issued brings the count to the quota
  function automatic logic quota_reached(logic [PARAM_W-1:0] issued,
                                         logic [PARAM_W-1:0] quota);
    return ({1'b0, issued} + (PARAM_W+1)'(1)) >= {1'b0, quota};
  endfunction

  function automatic logic burst_exceeds(logic [31:0] blen, logic [31:0] ceiling);
    return blen > ceiling;
  endfunction
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
  import arb_pkg::*;
#(
  parameter int unsigned N = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_addr,
  input  logic [PARAM_W-1:0]         cfg_wdata,
  output logic [N-1:0][PARAM_W-1:0]  limit_o,
  output logic [N-1:0][PARAM_W-1:0]  period_o,
  output logic [N-1:0][PARAM_W-1:0]  accept_o
);
  logic [PARAM_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                     sel_q <= '0;
    else if (cfg_we && cfg_reg_e'(cfg_addr) == CFG_SEL) sel_q <= cfg_wdata;
  end

  for (genvar a = 0; a < N; a++) begin : g_agent
    logic [PARAM_W-1:0] lim_q, prd_q, acc_q;
    logic               hit;
    assign hit = cfg_we && (sel_q == PARAM_W'(a));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lim_q <= reset_limit(a);
        prd_q <= reset_period(a);
        acc_q <= reset_accept(a);
      end else if (hit) begin
        case (cfg_reg_e'(cfg_addr))
          CFG_LIMIT:  lim_q <= cfg_wdata;
          CFG_PERIOD: prd_q <= cfg_wdata;
          CFG_ACCEPT: acc_q <= cfg_wdata;
          default:    ;
        endcase
      end
    end

    assign limit_o[a]  = lim_q;
    assign period_o[a] = prd_q;
    assign accept_o[a] = acc_q;
  end
endmodule

// File: rtl/arb_wait_timer.sv
module arb_wait_timer
  import arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               waiting,
  input  logic [PARAM_W-1:0] period,
  output logic               urgent
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !waiting) cnt_q <= '0;
    else if (cnt_q != {WAIT_W{1'b1}}) cnt_q <= cnt_q + WAIT_W'(1);
  end

  assign urgent = waiting && (cnt_q >= wait_threshold(period));
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned N     = 5,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] last,
  output logic [N-1:0]     pick_oh,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_any
);
  always_comb begin
    pick_oh  = '0;
    pick_idx = last;
    pick_any = 1'b0;
    for (int off = 1; off <= int'(N); off++) begin
      if (!pick_any && cand[(int'(last) + off) % int'(N)]) begin
        pick_any = 1'b1;
        pick_oh[(int'(last) + off) % int'(N)] = 1'b1;
        pick_idx = IDX_W'((int'(last) + off) % int'(N));
      end
    end
  end
endmodule

// File: rtl/agent_port_arbiter.sv
module agent_port_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned N_AGENTS = 5,
  parameter int unsigned BLEN_W   = 8,
  parameter int unsigned CMD_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_addr,
  input  logic [PARAM_W-1:0]         cfg_wdata,
  input  logic [N_AGENTS-1:0]        req_valid,
  input  logic [N_AGENTS*BLEN_W-1:0] req_blen,
  input  logic [N_AGENTS*CMD_W-1:0]  req_cmd,
  output logic [N_AGENTS-1:0]        grant,
  output logic                       cmd_valid,
  output logic [BLEN_W-1:0]          cmd_blen,
  output logic [CMD_W-1:0]           cmd_out
);
  localparam int unsigned IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

  logic [N_AGENTS-1:0][PARAM_W-1:0] limit_v, period_v, accept_v;
  logic [N_AGENTS-1:0] grant_q, urgent_vec, cand, pick_oh;
  logic [IDX_W-1:0]    last_q, pick_idx;
  logic                pick_any;
  logic [PARAM_W-1:0]  issue_cnt;
  logic [PARAM_W-1:0]  own_limit, own_accept;
  logic                owned, fire, quota_done, burst_over, dropped, release_ev, arb_load;

  arb_cfg_regs #(.N(N_AGENTS)) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .limit_o(limit_v), .period_o(period_v), .accept_o(accept_v)
  );

  for (genvar a = 0; a < N_AGENTS; a++) begin : g_wait
    arb_wait_timer i_wait (
      .clk(clk), .rst_n(rst_n),
      .waiting(req_valid[a] && !grant_q[a]),
      .period(period_v[a]),
      .urgent(urgent_vec[a])
    );
  end

  // forward the owner's command and settings
  always_comb begin
    cmd_out    = '0;
    cmd_blen   = '0;
    own_limit  = '0;
    own_accept = '0;
    for (int a = 0; a < int'(N_AGENTS); a++) begin
      if (grant_q[a]) begin
        cmd_out    |= req_cmd[a*CMD_W +: CMD_W];
        cmd_blen   |= req_blen[a*BLEN_W +: BLEN_W];
        own_limit  |= limit_v[a];
        own_accept |= accept_v[a];
      end
    end
  end

  assign owned      = |grant_q;
  assign fire       = |(grant_q & req_valid);
  assign quota_done = fire && quota_reached(issue_cnt, own_accept);
  assign burst_over = fire && burst_exceeds(32'(cmd_blen), 32'(own_limit));
  assign dropped    = owned && !fire;
  assign release_ev = quota_done || burst_over || dropped;
  assign arb_load   = !owned || release_ev;

  // waiting agents past their patience outrank plain requesters
  assign cand = (|urgent_vec) ? urgent_vec : req_valid;

  arb_rr_pick #(.N(N_AGENTS)) i_pick (
    .cand(cand), .last(last_q),
    .pick_oh(pick_oh), .pick_idx(pick_idx), .pick_any(pick_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q   <= '0;
      last_q    <= IDX_W'(N_AGENTS - 1);
      issue_cnt <= '0;
    end else if (arb_load) begin
      grant_q   <= pick_oh;
      issue_cnt <= '0;
      if (pick_any) last_q <= pick_idx;
    end else if (fire) begin
      issue_cnt <= issue_cnt + PARAM_W'(1);
    end
  end

  assign grant     = grant_q;
  assign cmd_valid = fire;
endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import arb_pkg::*;
#(
  parameter int unsigned N = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N-1:0]       grant,
  input logic [N-1:0]       req_valid,
  input logic               cmd_valid,
  input logic               arb_load,
  input logic               release_ev,
  input logic               burst_over,
  input logic [N-1:0]       urgent_vec,
  input logic [PARAM_W-1:0] issue_cnt
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R3

  AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    arb_load |=> ((grant & ~$past(req_valid)) == '0)); // R3

  AST_CMD_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($countones(grant) == 1)); // R4

  AST_HOLD_UNTIL_QUOTA: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !release_ev) |=> $stable(grant)); // R5

  AST_DROP_MOVES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && !cmd_valid) |=> ((grant & $past(grant)) == '0)); // R6

  AST_LONG_BURST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    burst_over |=> (issue_cnt == '0)); // R7

  AST_URGENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_load && ((urgent_vec & req_valid) != '0))
      |=> ((grant & $past(urgent_vec & req_valid)) != '0)); // R8
endmodule

bind agent_port_arbiter arb_checker #(.N(N_AGENTS)) i_arb_checker (
  .clk(clk), .rst_n(rst_n), .grant(grant), .req_valid(req_valid),
  .cmd_valid(cmd_valid), .arb_load(arb_load), .release_ev(release_ev),
  .burst_over(burst_over), .urgent_vec(urgent_vec), .issue_cnt(issue_cnt)
);

// File: tb/test_agent_port_arbiter.sv
`timescale 1ns/1ps
module test_agent_port_arbiter;
  localparam int N = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [7:0]    cfg_wdata = '0;
  logic [N-1:0]  req_valid;
  logic [N*8-1:0]  req_blen;
  logic [N*32-1:0] req_cmd;
  logic [N-1:0]  grant;
  logic          cmd_valid;
  logic [7:0]    cmd_blen;
  logic [31:0]   cmd_out;

  int         rem [N];
  logic [7:0] seq [N];
  logic [7:0] blen[N];
  logic [15:0] exp_q[$];
  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_drv
    assign req_valid[i]         = (rem[i] != 0);
    assign req_blen[i*8 +: 8]   = blen[i];
    assign req_cmd[i*32 +: 32]  = {16'h0, 8'(i), seq[i]};
  end

  agent_port_arbiter i_agent_port_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_blen(req_blen),
    .req_cmd(req_cmd), .grant(grant), .cmd_valid(cmd_valid),
    .cmd_blen(cmd_blen), .cmd_out(cmd_out)
  );

  // monitor: compare at negedge, advance accepted agents just after posedge
  always begin
    logic [N-1:0] fire_v;
    logic [15:0]  item;
    fire_v = '0;
    @(negedge clk);
    if (rst_n) begin
      if (cmd_valid) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL %s: unexpected command %h grant %b, expected none", cur_req, cmd_out, grant);
        end else begin
          item = exp_q.pop_front();
          if (cmd_out !== {16'h0, item} || grant !== (N'(1) << item[15:8]) ||
              cmd_blen !== blen[item[15:8]]) begin
            n_bad++;
            $display("FAIL %s: got cmd %h grant %b blen %0d, expected cmd %h grant %b blen %0d",
                     cur_req, cmd_out, grant, cmd_blen, {16'h0, item},
                     N'(1) << item[15:8], blen[item[15:8]]);
          end
        end
      end
      fire_v = grant & req_valid;
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      if (fire_v[i]) begin
        rem[i]--;
        seq[i]++;
      end
    end
  end

  task automatic expect_run(int agent, int first, int count);
    for (int k = 0; k < count; k++) exp_q.push_back({8'(agent), 8'(first + k)});
  endtask

  task automatic cfg_write(logic [1:0] addr, logic [7:0] data);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic start_agent(int agent, int count, logic [7:0] bl);
    seq[agent]  = '0;
    blen[agent] = bl;
    rem[agent]  = count;
  endtask

  task automatic wait_idle(string tag);
    int guard;
    bit busy;
    guard = 0;
    busy  = 1'b1;
    while (busy && guard < 2000) begin
      @(posedge clk);
      guard++;
      busy = 1'b0;
      for (int i = 0; i < N; i++) if (rem[i] != 0) busy = 1'b1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (busy || exp_q.size() != 0 || grant !== '0) begin
      n_bad++;
      $display("FAIL %s: end of scenario pending %0d grant %b busy %0b, expected 0 0 0",
               tag, exp_q.size(), grant, busy);
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      rem[i] = 0; seq[i] = '0; blen[i] = 8'd1;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    n_chk++;
    if (grant !== '0 || cmd_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: grant %b cmd_valid %b, expected 00000 0", grant, cmd_valid);
    end

    // R9 R10 R5 R6: agents 0 and 3, default quota 4 each, round robin from agent 0
    cur_req = "R9/R10/R5/R6";
    expect_run(0, 0, 4); expect_run(3, 0, 4); expect_run(0, 4, 2); expect_run(3, 4, 2);
    @(posedge clk); #2;
    start_agent(0, 6, 8'd1);
    start_agent(3, 6, 8'd1);
    wait_idle("R5");

    // R2 R7: agent 1 burst ceiling set to 2, its bursts of 5 end each tenure
    cur_req = "R2/R7";
    cfg_write(2'd0, 8'd1);
    cfg_write(2'd1, 8'd2);
    expect_run(1, 0, 1); expect_run(2, 0, 3); expect_run(1, 1, 2);
    @(posedge clk); #2;
    start_agent(1, 3, 8'd5);
    start_agent(2, 3, 8'd1);
    wait_idle("R7");

    // R2 R9: agent 2 quota set to 2, alternates with agent 4
    cur_req = "R2/R9";
    cfg_write(2'd0, 8'd2);
    cfg_write(2'd3, 8'd2);
    expect_run(2, 0, 2); expect_run(4, 0, 4); expect_run(2, 2, 2);
    @(posedge clk); #2;
    start_agent(2, 4, 8'd1);
    start_agent(4, 4, 8'd1);
    wait_idle("R2");

    // R8: agent 0 patience 1 (4 clocks) jumps ahead of agent 4
    cur_req = "R8";
    cfg_write(2'd0, 8'd0);
    cfg_write(2'd2, 8'd1);
    expect_run(3, 0, 4); expect_run(0, 0, 4); expect_run(4, 0, 4);
    @(posedge clk); #2;
    start_agent(0, 4, 8'd1);
    start_agent(3, 4, 8'd1);
    start_agent(4, 4, 8'd1);
    wait_idle("R8");

    // R4: single agent 1 with a burst within... ceiling 2, burst 2, quota 16
    cur_req = "R4";
    expect_run(1, 0, 5);
    @(posedge clk); #2;
    start_agent(1, 5, 8'd2);
    wait_idle("R4");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule